// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Encoder with Fault Injection

This block turns a serial transmit bit stream into a pair of bipolar line rails, one for positive pulses and one for negative pulses. Ones are sent as marks of alternating polarity. Long runs of zeros are replaced by substitution patterns that carry a deliberate polarity violation, so the far end keeps timing content. In the 3-zero mode a run of three spaces is replaced. In the 4-zero mode a run of four spaces is replaced. A binary select bypasses all line coding and sends the data, delayed, on the positive rail only.

For line testing, two one-shot requests can be raised. A violation request corrupts the polarity of one mark. An excessive-zeros request withholds one substitution, so a raw zero run goes out on the line. Each request is held until it has been used and then cleared. A new request is needed for each further fault.

Data advances only on cycles where the bit enable is high. The encoder looks ahead over a whole candidate zero run, so it has a fixed delay of one run length: 3 bit periods in the 3-zero mode and 4 in the 4-zero mode.

Top module: `zsl_line_encoder`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) drives both rails low, returns the polarity state to "last pulse negative", clears run counts and parity, and discards any pending request.
- R2: A bit sampled on an enabled cycle appears on the rails after exactly 3 further enabled cycles when `zero_run4` is 0, and after 4 when it is 1. The rails change only on cycles with `bit_en` high.
- R3: Rail encoding is: positive pulse `pos_out`=1, `neg_out`=0; negative pulse `pos_out`=0, `neg_out`=1; space both 0. Both rails are never high together. Ordinary marks alternate in polarity, and the first mark after reset is positive.
- R4: With `zero_run4`=0, every run of 3 input zeros is sent as 00V when the number of normal-polarity pulses since the last V is odd, and as B0V when it is even. B is a normal alternating pulse. V repeats the polarity of the pulse before it. After reset the count starts even.
- R5: With `zero_run4`=1, every run of 4 input zeros is sent as 000V (odd count) or B00V (even count), using the same parity and pulse rules as R4.
- R6: Successive V pulses from substitutions alternate in polarity. A binary-mode interval restarts this sequence.
- R7: After a pulse on `inj_bpv`, the next input one that is at least the third of an unbroken run of ones is sent with the same polarity as the previous pulse. The polarity state is left unchanged, so the following mark is of opposite polarity. This pulse does not count toward the substitution parity. Only one such violation is made per request.
- R8: After a pulse on `inj_exz`, the next substitution opportunity is skipped and those zeros are sent as spaces. The zero count then restarts, and later runs are substituted normally. Only one skip is made per request.
- R9: With `bypass_bin`=1, `pos_out` carries the data with the same delay as R2, and `neg_out` stays 0. No substitution or violation is produced. Requests arriving in this mode are discarded. Run counts and parity are cleared.
- R10: A request of either kind that arrives while a request of the same kind is pending, including on the cycle it is used, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit clock enable; data advances when high |
| bit_in | input | 1 | Transmit data bit |
| zero_run4 | input | 1 | 0: 3-zero substitution, 3-bit delay; 1: 4-zero substitution, 4-bit delay |
| bypass_bin | input | 1 | 1: unipolar binary output, coding and injection disabled |
| inj_bpv | input | 1 | One-shot request for a single bipolar violation |
| inj_exz | input | 1 | One-shot request for a single withheld substitution |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |

## Verification
The bench first checks the B-versus-plain choice against pulse parity in both run lengths. A design that got the parity wrong would send V pulses of the same polarity back to back, which the checker reports. It checks that a violation lands on the third one and not on the first, and that the next mark flips polarity again; an encoder that updated its polarity state on the fault would shift every later mark. It also checks that a withheld substitution leaves the next zero run coded normally, that a repeated or binary-mode request creates no second or hidden fault, and that a pause in `bit_en` neither moves the rails nor changes the fixed delay.

// File: rtl/zsl_pkg.sv
package zsl_pkg;

  // Line symbol held in the delay line until it reaches the rails.
  typedef enum logic [2:0] {
    SYM_SPACE = 3'd0,
    SYM_MARK  = 3'd1,
    SYM_BFILL = 3'd2,
    SYM_VIOL  = 3'd3,
    SYM_BPV   = 3'd4
  } sym_t;

  // Symbols that take the next alternating polarity.
  function automatic logic sym_flips(sym_t s);
    return (s == SYM_MARK) || (s == SYM_BFILL);
  endfunction

  // Symbols that put a pulse on a rail.
  function automatic logic sym_pulses(sym_t s);
    return s != SYM_SPACE;
  endfunction

  // Even count of alternating pulses since the last V selects the B form.
  function automatic logic need_bfill(logic parity_odd);
    return !parity_odd;
  endfunction

  // Polarity for a pulse, given the polarity of the previous pulse.
  function automatic logic pulse_pol(sym_t s, logic last_pos);
    return sym_flips(s) ? !last_pos : last_pos;
  endfunction

endpackage

// File: rtl/zsl_inject_arm.sv
module zsl_inject_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_bin,
  input  logic inj_bpv,
  input  logic inj_exz,
  input  logic bpv_fire,
  input  logic exz_fire,
  output logic bpv_pend,
  output logic exz_pend
);

  // A request is taken only when none of its kind is pending; the use clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpv_pend <= 1'b0;
      exz_pend <= 1'b0;
    end else if (bypass_bin) begin
      bpv_pend <= 1'b0;
      exz_pend <= 1'b0;
    end else begin
      bpv_pend <= bpv_pend ? !bpv_fire : inj_bpv;
      exz_pend <= exz_pend ? !exz_fire : inj_exz;
    end
  end

endmodule

// File: rtl/zsl_subst_ctrl.sv
module zsl_subst_ctrl
  import zsl_pkg::*;
#(
  parameter int unsigned RUN_SHORT = 3,
  parameter int unsigned RUN_LONG  = 4,
  parameter int unsigned BPV_RUN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic zero_run4,
  input  logic bypass_bin,
  input  logic bpv_pend,
  input  logic exz_pend,
  output sym_t new_sym,
  output logic set_bfill,
  output logic subst_fire,
  output logic bpv_fire,
  output logic exz_fire
);

  localparam int unsigned ZW = $clog2(RUN_LONG + 1);
  localparam int unsigned OW = $clog2(BPV_RUN + 1);
  localparam logic [OW-1:0] ONES_FULL = OW'(BPV_RUN - 1);

  logic [ZW-1:0] zrun;
  logic [ZW-1:0] run_len;
  logic [OW-1:0] orun;
  logic          par_odd;
  logic          zero_opp;

  always_comb begin
    run_len    = zero_run4 ? ZW'(RUN_LONG) : ZW'(RUN_SHORT);
    zero_opp   = bit_en && !bypass_bin && !bit_in && (zrun >= run_len - 1'b1);
    subst_fire = zero_opp && !exz_pend;
    exz_fire   = zero_opp && exz_pend;
    bpv_fire   = bit_en && !bypass_bin && bit_in && bpv_pend && (orun == ONES_FULL);
    set_bfill  = subst_fire && need_bfill(par_odd);
    if (bypass_bin)      new_sym = bit_in ? SYM_MARK : SYM_SPACE;
    else if (subst_fire) new_sym = SYM_VIOL;
    else if (bpv_fire)   new_sym = SYM_BPV;
    else if (bit_in)     new_sym = SYM_MARK;
    else                 new_sym = SYM_SPACE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun    <= '0;
      orun    <= '0;
      par_odd <= 1'b0;
    end else if (bit_en) begin
      if (bypass_bin) begin
        zrun    <= '0;
        orun    <= '0;
        par_odd <= 1'b0;
      end else if (bit_in) begin
        zrun <= '0;
        if (bpv_fire) begin
          orun <= '0;
        end else begin
          if (orun != ONES_FULL) orun <= orun + 1'b1;
          par_odd <= !par_odd;
        end
      end else begin
        orun <= '0;
        if (subst_fire) begin
          zrun    <= '0;
          par_odd <= 1'b0;
        end else if (exz_fire) begin
          zrun <= '0;
        end else begin
          zrun <= zrun + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/zsl_sym_pipe.sv
module zsl_sym_pipe
  import zsl_pkg::*;
#(
  parameter int unsigned RUN_SHORT = 3,
  parameter int unsigned RUN_LONG  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic zero_run4,
  input  sym_t new_sym,
  input  logic set_bfill,
  output sym_t tail_sym
);

  localparam int unsigned DEPTH = RUN_LONG;

  sym_t stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage[0] <= SYM_SPACE;
    else if (shift) stage[0] <= new_sym;
  end

  // The oldest zero of a substituted run lands in the tap stage as B.
  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    localparam bit IS_SHORT_TAP = (k == RUN_SHORT - 1);
    localparam bit IS_LONG_TAP  = (k == RUN_LONG - 1);
    logic rewrite;
    assign rewrite = set_bfill && (zero_run4 ? IS_LONG_TAP : IS_SHORT_TAP);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage[k] <= SYM_SPACE;
      else if (shift) stage[k] <= rewrite ? SYM_BFILL : stage[k-1];
    end
  end

  assign tail_sym = zero_run4 ? stage[RUN_LONG-1] : stage[RUN_SHORT-1];

endmodule

// File: rtl/zsl_ami_out.sv
module zsl_ami_out
  import zsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic bypass_bin,
  input  sym_t tail_sym,
  output logic pos_out,
  output logic neg_out,
  output logic v_emit,
  output logic v_pol
);

  logic last_pos;
  logic this_pos;
  logic pulse;

  always_comb begin
    this_pos = pulse_pol(tail_sym, last_pos);
    pulse    = sym_pulses(tail_sym);
  end

  assign v_emit = shift && !bypass_bin && (tail_sym == SYM_VIOL);
  assign v_pol  = this_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
      last_pos <= 1'b0;
    end else if (shift) begin
      if (bypass_bin) begin
        pos_out <= pulse;
        neg_out <= 1'b0;
      end else begin
        pos_out <= pulse && this_pos;
        neg_out <= pulse && !this_pos;
        if (pulse) last_pos <= this_pos;
      end
    end
  end

endmodule

// File: rtl/zsl_line_encoder.sv
module zsl_line_encoder
  import zsl_pkg::*;
#(
  parameter int unsigned RUN_SHORT = 3,
  parameter int unsigned RUN_LONG  = 4,
  parameter int unsigned BPV_RUN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic zero_run4,
  input  logic bypass_bin,
  input  logic inj_bpv,
  input  logic inj_exz,
  output logic pos_out,
  output logic neg_out
);

  sym_t new_sym;
  sym_t tail_sym;
  logic set_bfill;
  logic subst_fire;
  logic bpv_fire;
  logic exz_fire;
  logic bpv_pend;
  logic exz_pend;
  logic v_emit;
  logic v_pol;

  zsl_inject_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass_bin (bypass_bin),
    .inj_bpv    (inj_bpv),
    .inj_exz    (inj_exz),
    .bpv_fire   (bpv_fire),
    .exz_fire   (exz_fire),
    .bpv_pend   (bpv_pend),
    .exz_pend   (exz_pend)
  );

  zsl_subst_ctrl #(
    .RUN_SHORT (RUN_SHORT),
    .RUN_LONG  (RUN_LONG),
    .BPV_RUN   (BPV_RUN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .zero_run4  (zero_run4),
    .bypass_bin (bypass_bin),
    .bpv_pend   (bpv_pend),
    .exz_pend   (exz_pend),
    .new_sym    (new_sym),
    .set_bfill  (set_bfill),
    .subst_fire (subst_fire),
    .bpv_fire   (bpv_fire),
    .exz_fire   (exz_fire)
  );

  zsl_sym_pipe #(
    .RUN_SHORT (RUN_SHORT),
    .RUN_LONG  (RUN_LONG)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift     (bit_en),
    .zero_run4 (zero_run4),
    .new_sym   (new_sym),
    .set_bfill (set_bfill),
    .tail_sym  (tail_sym)
  );

  zsl_ami_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift      (bit_en),
    .bypass_bin (bypass_bin),
    .tail_sym   (tail_sym),
    .pos_out    (pos_out),
    .neg_out    (neg_out),
    .v_emit     (v_emit),
    .v_pol      (v_pol)
  );

endmodule

// File: rtl/zsl_line_encoder_chk.sv
module zsl_line_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic bypass_bin,
  input logic pos_out,
  input logic neg_out,
  input logic bpv_fire,
  input logic exz_fire,
  input logic bpv_pend,
  input logic exz_pend,
  input logic v_emit,
  input logic v_pol
);

  logic have_v;
  logic last_v_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_v     <= 1'b0;
      last_v_pos <= 1'b0;
    end else if (bypass_bin) begin
      have_v <= 1'b0;
    end else if (v_emit) begin
      have_v     <= 1'b1;
      last_v_pos <= v_pol;
    end
  end

  p_rails_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({pos_out, neg_out}));

  p_binary_unipolar_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_bin && bit_en) |=> !neg_out);

  p_no_inject_binary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_bin |-> !(bpv_fire || exz_fire));

  p_v_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_emit && have_v) |-> (v_pol != last_v_pos));

  p_bpv_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_fire |=> !bpv_pend);

  p_exz_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exz_fire |=> !exz_pend);

endmodule

bind zsl_line_encoder zsl_line_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .bypass_bin (bypass_bin),
  .pos_out    (pos_out),
  .neg_out    (neg_out),
  .bpv_fire   (bpv_fire),
  .exz_fire   (exz_fire),
  .bpv_pend   (bpv_pend),
  .exz_pend   (exz_pend),
  .v_emit     (v_emit),
  .v_pol      (v_pol)
);

// File: tb/test_zsl_line_encoder.sv
`timescale 1ns/1ps
module test_zsl_line_encoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic zero_run4 = 1'b0;
  logic bypass_bin = 1'b0;
  logic inj_bpv = 1'b0;
  logic inj_exz = 1'b0;
  logic pos_out;
  logic neg_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zsl_line_encoder i_zsl_line_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .zero_run4  (zero_run4),
    .bypass_bin (bypass_bin),
    .inj_bpv    (inj_bpv),
    .inj_exz    (inj_exz),
    .pos_out    (pos_out),
    .neg_out    (neg_out)
  );

  // Stimulus and expected rails, first bit in the MSB.
  typedef struct packed {
    logic        e3;
    logic        bin;
    logic [11:0] bits;
    logic [11:0] epos;
    logic [11:0] eneg;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 12'b010101010101, 12'b010001000100, 12'b000100010001},
    '{1'b0, 1'b0, 12'b100011000001, 12'b100101000001, 12'b000010101000},
    '{1'b1, 1'b0, 12'b100001000001, 12'b100010000001, 12'b000001000100},
    '{1'b1, 1'b0, 12'b000011000011, 12'b100101000010, 12'b000010100101},
    '{1'b0, 1'b1, 12'b100011000001, 12'b100011000001, 12'b000000000000}
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rails pos/neg=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; inj_bpv = 1'b0; inj_exz = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset rails", {pos_out, neg_out}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic pulse_req(input bit bpv, input bit exz);
    @(negedge clk);
    inj_bpv = bpv; inj_exz = exz;
    @(negedge clk);
    inj_bpv = 1'b0; inj_exz = 1'b0;
  endtask

  // Feeds n bits on consecutive enabled cycles, then zeros, and compares each
  // output symbol at its fixed delay.
  task automatic run_seq(input string tag, input int n, input logic [15:0] bits,
                         input logic [15:0] epos, input logic [15:0] eneg);
    int lat;
    lat = zero_run4 ? 4 : 3;
    for (int c = 0; c <= n + lat; c++) begin
      @(negedge clk);
      if (c >= 1 && (c - 1 - lat) >= 0 && (c - 1 - lat) < n) begin
        int idx;
        idx = c - 1 - lat;
        check($sformatf("%s bit %0d", tag, idx), {pos_out, neg_out},
              {epos[n-1-idx], eneg[n-1-idx]});
      end
      bit_en = 1'b1;
      bit_in = (c < n) ? bits[n-1-c] : 1'b0;
    end
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'b0;
  endtask

  function automatic string vec_tag(vec_t v);
    if (v.bin) return "R9 binary";
    if (v.e3)  return "R5 four-zero";
    return "R3 R4 three-zero";
  endfunction

  initial begin
    // Table-driven patterns, one reset each.
    for (int i = 0; i < 5; i++) begin
      zero_run4 = VECS[i].e3;
      bypass_bin = VECS[i].bin;
      do_reset();
      run_seq(vec_tag(VECS[i]), 12, {4'b0, VECS[i].bits},
              {4'b0, VECS[i].epos}, {4'b0, VECS[i].eneg});
    end

    // R1: a pending request is dropped by reset.
    zero_run4 = 1'b0; bypass_bin = 1'b0;
    do_reset();
    pulse_req(1'b1, 1'b0);
    do_reset();
    run_seq("R1 pending cleared", 3, 16'b111, 16'b101, 16'b010);

    // R2: enable gaps hold the rails and do not count toward the delay.
    do_reset();
    @(negedge clk); bit_en = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_en = 1'b0; bit_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 hold during gap", {pos_out, neg_out}, 2'b00);
    bit_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bit_en = 1'b0;
    check("R2 before delay", {pos_out, neg_out}, 2'b00);
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    check("R2 after three enables", {pos_out, neg_out}, 2'b10);
    repeat (3) @(negedge clk);
    check("R2 stable with enable low", {pos_out, neg_out}, 2'b10);

    // R7: violation on the third one only, polarity state unchanged.
    do_reset();
    pulse_req(1'b1, 1'b0);
    run_seq("R7 violation", 8, 16'b11110111, 16'b10010010, 16'b01100101);

    // R10: a second request while pending adds nothing.
    do_reset();
    pulse_req(1'b1, 1'b0);
    pulse_req(1'b1, 1'b0);
    run_seq("R10 repeated request", 6, 16'b111111, 16'b100101, 16'b011010);

    // R8: one substitution withheld, the next run coded normally.
    do_reset();
    pulse_req(1'b0, 1'b1);
    run_seq("R8 withheld substitution", 9, 16'b100010001, 16'b100001010, 16'b000010001);

    // R9: requests in binary mode are discarded; R6 sequence restarts.
    do_reset();
    bypass_bin = 1'b1;
    pulse_req(1'b1, 1'b1);
    run_seq("R9 binary zeros", 4, 16'b0000, 16'b0000, 16'b0000);
    bypass_bin = 1'b0;
    run_seq("R9 R6 after binary", 7, 16'b1110001, 16'b1010010, 16'b0100001);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run incomplete, expected finish before limit");
      report();
      $finish;
    end
  end

endmodule